// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one timer channel with a small word-addressed register port and a single interrupt line. A 32-bit counter decrements once for each prescaled tick. The prescaler divides an external clock-enable tick by 1, 16 or 256. The counter works in one of three modes. In free-running mode it wraps at full scale. In periodic mode it restarts from a programmed period. In one-shot mode it halts at zero. Each mode can use a 16-bit or a 32-bit counter width.

Software programs the period in one of two ways. An immediate load restarts the count at once. A background load only replaces the period and leaves the running count alone, so the new period starts at the next wrap. When the counter reaches zero it sets a raw interrupt flag. A masked copy of that flag, gated by an enable bit, drives the interrupt pin. Writing the clear offset drops the flag.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable set, timer stopped, free-running, 16-bit), the count reads 0 and the raw flag reads 0.
- R2: Control bits [3:2] select the prescale. 00 gives one counter step per tick, 01 one step per 16 ticks and 10 one step per 256 ticks; 11 behaves as 00. Ticks count only while the enable bit (bit 7) is set.
- R3: In periodic mode (bit 6 set, bit 0 clear) each step lowers the count by one. A step taken at zero reloads the count from the load register.
- R4: In one-shot mode (bit 0 set, which takes precedence over bit 6) the count stays at zero once it gets there, until a reload.
- R5: With bits 0 and 6 both clear the counter is free-running, and every reload uses full scale: 0xFFFF with bit 1 clear and 0xFFFFFFFF with bit 1 set.
- R6: With bit 1 clear only the low 16 bits count and are compared with zero. The count reads with its upper 16 bits as zero, and a periodic reload takes the low 16 bits of the load value.
- R7: A write to word offset 0 stores the load value and reloads the count at once with the reload value of the current mode. Writes to offset 1 change nothing.
- R8: A write to offset 6 stores the load value and leaves the count unchanged. The new value is used at the next wrap.
- R9: The raw flag (read at offset 4, bit 0) sets on the step that takes the count from 1 to 0. Any write to offset 3 clears it. If a set and a clear fall in the same cycle, the set wins.
- R10: The masked status (offset 5) and the `irq` output both equal the raw flag ANDed with control bit 5.
- R11: A control write (offset 2) restarts the prescaler. If the written value has bit 7 set, the write also reloads the count with the reload value of the new mode.
- R12: Offsets 0 and 6 read the load value, 1 the count and 2 the control byte. Offsets 3 and 7, and any read with `rd_en` low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Clock-enable tick feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Interrupt, masked status |

## Verification
The assertions assume that at most one register access happens per cycle, and that `addr` and `wdata` are valid whenever `wr_en` is high. They also assume that `tick_en` is a level that may stay high for many cycles, with no width limit. The bench changes all inputs on the falling clock edge, drives only one strobe at a time, and holds `tick_en` high for exact cycle counts. Every expected count therefore equals the initial value minus the number of prescaled steps.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W    = 32;
  localparam int NARROW_W = 16;
  localparam int PSCL_W   = 8;
  localparam int ADDR_W   = 3;

  // word offsets
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_VALUE = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_BGLD  = 3'd6;

  typedef struct packed {
    logic       run;      // bit 7
    logic       periodic; // bit 6
    logic       int_en;   // bit 5
    logic       spare;    // bit 4
    logic [1:0] pscl;     // bits 3:2
    logic       wide;     // bit 1
    logic       oneshot;  // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = 8'h20;

  // last prescaler count before a step
  function automatic logic [PSCL_W-1:0] pscl_last(input logic [1:0] sel);
    case (sel)
      2'b01:   pscl_last = PSCL_W'(15);
      2'b10:   pscl_last = PSCL_W'(255);
      default: pscl_last = '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] full_scale(input logic wide);
    full_scale = wide ? {CNT_W{1'b1}} : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  endfunction

  function automatic logic [CNT_W-1:0] width_view(input logic [CNT_W-1:0] v,
                                                  input logic wide);
    width_view = wide ? v : {{(CNT_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
  endfunction

  function automatic logic [CNT_W-1:0] reload_value(input ctrl_t c,
                                                    input logic [CNT_W-1:0] load);
    if (!c.oneshot && !c.periodic) reload_value = full_scale(c.wide);
    else                           reload_value = width_view(load, c.wide);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick_en,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       pulse
);
  logic [PSCL_W-1:0] pcnt;
  logic [PSCL_W-1:0] last;

  assign last  = pscl_last(sel);
  assign pulse = run && tick_en && (pcnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart)  pcnt <= '0;
    else if (run && tick_en) pcnt <= (pcnt == last) ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] load,
  input  logic             step_req,
  input  logic             imm_reload,
  input  logic [CNT_W-1:0] imm_value,
  input  logic             hold_step,
  output logic [CNT_W-1:0] view,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             step;

  assign view   = width_view(cnt, ctrl.wide);
  assign step   = step_req && !hold_step && !imm_reload;
  assign expire = step && (view == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (imm_reload) cnt <= imm_value;
    else if (step) begin
      if (view != '0)         cnt <= view - 1'b1;
      else if (!ctrl.oneshot) cnt <= reload_value(ctrl, load);
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt_view,
  input  logic              expire,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  load_q,
  output logic              raw_q,
  output logic              ld_wr,
  output logic              bg_wr,
  output logic              ctrl_wr,
  output logic              clr_wr,
  output logic [CNT_W-1:0]  rdata
);
  assign ld_wr   = wr_en && (addr == OFS_LOAD);
  assign bg_wr   = wr_en && (addr == OFS_BGLD);
  assign ctrl_wr = wr_en && (addr == OFS_CTRL);
  assign clr_wr  = wr_en && (addr == OFS_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      load_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (ctrl_wr)         ctrl_q <= ctrl_t'(wdata[7:0]);
      if (ld_wr || bg_wr)  load_q <= wdata;
      if (expire)          raw_q  <= 1'b1;
      else if (clr_wr)     raw_q  <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_LOAD, OFS_BGLD: rdata = load_q;
        OFS_VALUE:          rdata = cnt_view;
        OFS_CTRL:           rdata = {{(CNT_W-8){1'b0}}, ctrl_q};
        OFS_RAW:            rdata = {{(CNT_W-1){1'b0}}, raw_q};
        OFS_MASK:           rdata = {{(CNT_W-1){1'b0}}, raw_q & ctrl_q.int_en};
        default:            rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_new;
  logic [CNT_W-1:0] load_q;
  logic             raw_q;
  logic             ld_wr, bg_wr, ctrl_wr, clr_wr;
  logic             pulse;
  logic             expire;
  logic             imm_reload;
  logic [CNT_W-1:0] imm_value;
  logic [CNT_W-1:0] cnt_view;

  assign ctrl_new = ctrl_t'(wdata[7:0]);

  tmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_view(cnt_view), .expire(expire), .ctrl_q(ctrl_q),
    .load_q(load_q), .raw_q(raw_q), .ld_wr(ld_wr), .bg_wr(bg_wr),
    .ctrl_wr(ctrl_wr), .clr_wr(clr_wr), .rdata(rdata)
  );

  // R11: control write restarts the prescaler
  tmr_prescaler u_pscl (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick_en(tick_en),
    .restart(ctrl_wr), .sel(ctrl_q.pscl), .pulse(pulse)
  );

  // R7 / R11: immediate reload sources
  always_comb begin
    imm_reload = 1'b0;
    imm_value  = '0;
    if (ld_wr) begin
      imm_reload = 1'b1;
      imm_value  = reload_value(ctrl_q, wdata);
    end else if (ctrl_wr && ctrl_new.run) begin
      imm_reload = 1'b1;
      imm_value  = reload_value(ctrl_new, load_q);
    end
  end

  tmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .load(load_q),
    .step_req(pulse), .imm_reload(imm_reload), .imm_value(imm_value),
    .hold_step(ctrl_wr), .view(cnt_view), .expire(expire)
  );

  // R10
  assign irq = raw_q & ctrl_q.int_en;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              tick_en,
  input logic              pulse,
  input logic              expire,
  input logic              raw_q,
  input logic [7:0]        ctrl_q,
  input logic [CNT_W-1:0]  cnt_view,
  input logic              imm_reload,
  input logic              ctrl_wr,
  input logic              irq
);
  // R9
  expire_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q);

  // R9
  clear_drops_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CLR && !expire) |=> !raw_q);

  // R10
  irq_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (raw_q && ctrl_q[5]));

  // R7
  value_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_VALUE && !ctrl_q[7]) |=> $stable(cnt_view));

  // R8
  bgload_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_BGLD && !ctrl_q[7]) |=> $stable(cnt_view));

  // R4
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && ctrl_q[0] && cnt_view == '0 && !imm_reload && !ctrl_wr)
      |=> cnt_view == '0);

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !imm_reload && !ctrl_wr && cnt_view > CNT_W'(1))
      |=> cnt_view == $past(cnt_view) - 1'b1);

  // R2
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (tick_en && ctrl_q[7]));
endmodule

bind tmr_chan tmr_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .tick_en(tick_en),
  .pulse(pulse), .expire(expire), .raw_q(raw_q), .ctrl_q(ctrl_q),
  .cnt_view(cnt_view), .imm_reload(imm_reload), .ctrl_wr(ctrl_wr), .irq(irq)
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
  // op: 0 write, 1 read-compare, 2 tick cycles, 3 irq compare
  localparam int NV = 28;
  localparam logic [68:0] VEC [NV] = '{
    {2'd1, 3'd2, 32'd0,     32'h20},       // R1 control reset
    {2'd1, 3'd1, 32'd0,     32'd0},        // R1 count reset
    {2'd1, 3'd4, 32'd0,     32'd0},        // R1 raw reset
    {2'd0, 3'd0, 32'd100,   32'd0},        // R7 load write
    {2'd1, 3'd1, 32'd0,     32'hFFFF},     // R5 free 16 reload
    {2'd1, 3'd0, 32'd0,     32'd100},      // R12 load readback
    {2'd1, 3'd6, 32'd0,     32'd100},      // R12 alias readback
    {2'd0, 3'd2, 32'hE2,    32'd0},        // R11 enable periodic 32
    {2'd1, 3'd1, 32'd0,     32'd100},      // R11 reload on enable
    {2'd2, 3'd0, 32'd10,    32'd0},
    {2'd1, 3'd1, 32'd0,     32'd90},       // R3 decrement
    {2'd0, 3'd1, 32'd5,     32'd0},        // R7 value write
    {2'd1, 3'd1, 32'd0,     32'd90},       // R7 ignored
    {2'd0, 3'd6, 32'd40,    32'd0},        // R8 background load
    {2'd1, 3'd1, 32'd0,     32'd90},       // R8 count untouched
    {2'd1, 3'd0, 32'd0,     32'd40},       // R8 load updated
    {2'd2, 3'd0, 32'd90,    32'd0},
    {2'd1, 3'd1, 32'd0,     32'd0},        // R3 reached zero
    {2'd1, 3'd4, 32'd0,     32'd1},        // R9 raw set
    {2'd1, 3'd5, 32'd0,     32'd1},        // R10 masked
    {2'd3, 3'd0, 32'd0,     32'd1},        // R10 irq high
    {2'd2, 3'd0, 32'd1,     32'd0},
    {2'd1, 3'd1, 32'd0,     32'd40},       // R8 new period at wrap
    {2'd0, 3'd3, 32'd0,     32'd0},        // R9 clear
    {2'd1, 3'd4, 32'd0,     32'd0},        // R9 raw cleared
    {2'd3, 3'd0, 32'd0,     32'd0},        // R10 irq low
    {2'd1, 3'd7, 32'd0,     32'd0},        // R12 unused offset
    {2'd1, 3'd2, 32'd0,     32'hE2}        // R12 control readback
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tmr_chan u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [2:0]  a;
      logic [31:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        2'd0: wr(a, d);
        2'd1: rchk($sformatf("table row %0d", i), a, e);
        2'd2: ticks(int'(d));
        default: chk($sformatf("table row %0d irq", i), {31'd0, irq}, e);
      endcase
    end

    // one-shot, 32-bit, divide by 16, interrupt masked
    wr(3'd2, 32'h00);
    wr(3'd0, 32'd20);
    rchk("R5 free 16 load", 3'd1, 32'hFFFF);
    wr(3'd2, 32'h87);
    rchk("R11 reload", 3'd1, 32'd20);
    ticks(48);
    rchk("R2 div16", 3'd1, 32'd17);
    ticks(272);
    rchk("R4 oneshot zero", 3'd1, 32'd0);
    rchk("R9 raw oneshot", 3'd4, 32'd1);
    rchk("R10 masked off", 3'd5, 32'd0);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    ticks(100);
    rchk("R4 oneshot stays", 3'd1, 32'd0);

    // divide by 256, periodic
    wr(3'd3, 32'd0);
    wr(3'd2, 32'hCA);
    rchk("R11 reload periodic", 3'd1, 32'd20);
    ticks(255);
    rchk("R2 div256 no step", 3'd1, 32'd20);
    ticks(1);
    rchk("R2 div256 step", 3'd1, 32'd19);

    // free-running 16-bit wrap
    wr(3'd2, 32'h00);
    wr(3'd0, 32'h12345);
    wr(3'd2, 32'h80);
    rchk("R5 free 16 start", 3'd1, 32'hFFFF);
    ticks(65535);
    rchk("R5 free 16 zero", 3'd1, 32'd0);
    rchk("R9 raw free", 3'd4, 32'd1);
    ticks(1);
    rchk("R5 free 16 wrap", 3'd1, 32'hFFFF);

    // free-running 32-bit
    wr(3'd2, 32'h82);
    rchk("R5 free 32 start", 3'd1, 32'hFFFF_FFFF);
    ticks(5);
    rchk("R5 free 32 count", 3'd1, 32'hFFFF_FFFA);

    // periodic 16-bit
    wr(3'd2, 32'hC0);
    rchk("R6 narrow reload", 3'd1, 32'h2345);
    ticks(1);
    rchk("R6 narrow step", 3'd1, 32'h2344);
    rchk("R12 full load kept", 3'd0, 32'h12345);

    // prescaler restart on control write
    wr(3'd2, 32'hC4);
    ticks(10);
    wr(3'd2, 32'hC4);
    rchk("R11 reload again", 3'd1, 32'h2345);
    ticks(15);
    rchk("R11 prescaler restarted", 3'd1, 32'h2345);
    ticks(1);
    rchk("R11 step after 16", 3'd1, 32'h2344);
    rchk("R12 clear offset reads 0", 3'd3, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule